// File: doc/BRIEF.md
# Subword Parallel Adder with Carry Elimination

This block is a 32-bit adder/subtractor whose datapath can be split into independent lanes. A mode input selects one 32-bit lane, two 16-bit lanes or four 8-bit lanes. In every mode the same parallel-prefix carry network is used. Lanes are separated by editing the generate and propagate terms at the lowest bit of each lane, which cuts off the incoming carry. The carry chain itself is never gated.

An operation input picks what each lane returns. The choices are the wrapped sum or difference, a halving average that keeps the lane's extra carry bit, a signed saturating result, or an unsigned saturating result. The packed result and the per-lane carry and overflow flags are registered, so they appear one clock after the inputs.

Top module: `subword_adder`

## Requirements
- R1: While rst_ni is low, sum_o, cout_o and ovf_o are all zero.
- R2: With mode_i = 00 and op_i = 00, sum_o is a_i + b_i modulo 2^32. When sub_i = 1 it is a_i - b_i, formed as a_i + ~b_i + 1.
- R3: With mode_i = 01, bits [15:0] and [31:16] are two separate 16-bit lanes. Lane 0 is the low half and lane 1 is the high half. Each lane is computed on its own with carry-in sub_i.
- R4: With mode_i = 10 or 11, the four bytes are separate 8-bit lanes. Lane n occupies bits [8n+7:8n].
- R5: A carry or borrow produced in one lane never changes the result or the flags of the lane above it.
- R6: cout_o[n] is the carry out of lane n's most significant bit. When subtracting, 1 means no borrow. Flag bits for lanes that do not exist in the current mode read 0.
- R7: ovf_o[n] is lane n's two's-complement overflow: the carry into the lane's top bit differs from the carry out of it. Flag bits for lanes that do not exist read 0.
- R8: op_i = 01 (average) shifts each lane's raw result right by one bit. The bit shifted in at the lane's top is the lane carry for an add, or the inverted carry for a subtract.
- R9: op_i = 10 (signed saturate) replaces a lane that overflowed with its signed maximum if the lane's a_i sign bit is 0, and with its signed minimum otherwise. Lanes without overflow keep the wrapped result.
- R10: op_i = 11 (unsigned saturate) sets a lane to all ones when an add carries out. It sets a lane to zero when a subtract borrows. Otherwise the lane keeps the wrapped result.
- R11: All outputs change only at the rising clock edge that follows the inputs. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| sub_i | input | 1 | 1 selects a_i - b_i in every lane |
| mode_i | input | 2 | Lane split: 00 one 32-bit, 01 two 16-bit, 10/11 four 8-bit |
| op_i | input | 2 | Result kind: 00 wrap, 01 average, 10 signed saturate, 11 unsigned saturate |
| sum_o | output | 32 | Registered packed result |
| cout_o | output | 4 | Registered carry out per lane, indexed by lane number |
| ovf_o | output | 4 | Registered signed overflow per lane, indexed by lane number |

## Verification
Every output is due exactly one rising edge after the inputs that produced it. The bench drives each vector on a falling edge and samples on the next falling edge, so exactly one register stage lies between drive and sample. A short delay after each drive, it also confirms that the outputs still carry the previous vector's values. This shows that nothing reaches the outputs combinationally. The expected result comes from a behavioural lane model that uses wide integers and is evaluated once per vector. The per-cycle sampling therefore always compares against the vector applied one clock earlier.

// File: rtl/subword_pkg.sv
package subword_pkg;
  typedef enum logic [1:0] {
    MODE_W32 = 2'b00,
    MODE_H16 = 2'b01,
    MODE_B8  = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OP_WRAP = 2'b00,
    OP_AVG  = 2'b01,
    OP_SSAT = 2'b10,
    OP_USAT = 2'b11
  } op_e;
endpackage

// File: rtl/sw_lane_map.sv
module sw_lane_map
  import subword_pkg::*;
#(
  parameter int NB = 4,
  localparam int IW = $clog2(NB)
) (
  input  mode_e                  mode_i,
  output logic [NB-1:0]          split_o,   // byte starts a lane
  output logic [NB-1:0]          top_o,     // byte ends a lane
  output logic [NB-1:0][IW-1:0]  owner_o,   // top byte of the lane holding each byte
  output logic [NB-1:0]          lane_vld_o,
  output logic [NB-1:0][IW-1:0]  lane_top_o
);
  always_comb begin
    for (int k = 0; k < NB; k++) begin
      unique case (mode_i)
        MODE_W32: begin
          split_o[k]    = (k == 0);
          top_o[k]      = (k == NB-1);
          owner_o[k]    = IW'(NB-1);
          lane_vld_o[k] = (k == 0);
          lane_top_o[k] = IW'(NB-1);
        end
        MODE_H16: begin
          split_o[k]    = (k % 2 == 0);
          top_o[k]      = (k % 2 == 1);
          owner_o[k]    = IW'(k | 1);
          lane_vld_o[k] = (k < NB/2);
          lane_top_o[k] = IW'((2*k + 1) % NB);
        end
        default: begin
          split_o[k]    = 1'b1;
          top_o[k]      = 1'b1;
          owner_o[k]    = IW'(k);
          lane_vld_o[k] = 1'b1;
          lane_top_o[k] = IW'(k);
        end
      endcase
    end
  end
endmodule

// File: rtl/sw_prefix_adder.sv
module sw_prefix_adder #(
  parameter int W      = 32,
  parameter int LANE_W = 8,
  localparam int NB    = W / LANE_W,
  localparam int LV    = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          cin_i,
  input  logic [NB-1:0] split_i,
  output logic [W-1:0]  sum_o,
  output logic [W-1:0]  cin_eff_o,  // carry into each bit
  output logic [W-1:0]  cout_o      // carry out of each bit
);
  logic [W-1:0] g0, p0, cut;
  logic [W-1:0] gg [LV+1];
  logic [W-1:0] pp [LV+1];

  assign g0 = a_i & b_i;
  assign p0 = a_i ^ b_i;

  for (genvar i = 0; i < W; i++) begin : g_cut
    if (i % LANE_W == 0) begin : g_lsb
      assign cut[i] = split_i[i / LANE_W];
    end else begin : g_mid
      assign cut[i] = 1'b0;
    end
  end

  // at a cut LSB: the lane's own carry-in replaces the incoming carry
  assign gg[0] = g0 | (p0 & cut & {W{cin_i}});
  assign pp[0] = p0 & ~cut;

  for (genvar l = 1; l <= LV; l++) begin : g_lvl
    localparam int D = 1 << (l - 1);
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_cmb
        assign gg[l][i] = gg[l-1][i] | (pp[l-1][i] & gg[l-1][i-D]);
        assign pp[l][i] = pp[l-1][i] & pp[l-1][i-D];
      end else begin : g_pass
        assign gg[l][i] = gg[l-1][i];
        assign pp[l][i] = pp[l-1][i];
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_sum
    if (i == 0) begin : g_b0
      assign cin_eff_o[i] = cin_i;
    end else begin : g_bn
      assign cin_eff_o[i] = cut[i] ? cin_i : gg[LV][i-1];
    end
  end

  assign sum_o  = p0 ^ cin_eff_o;
  assign cout_o = gg[LV];
endmodule

// File: rtl/sw_lane_post.sv
module sw_lane_post
  import subword_pkg::*;
#(
  parameter int W      = 32,
  parameter int LANE_W = 8,
  localparam int NB    = W / LANE_W,
  localparam int IW    = $clog2(NB)
) (
  input  op_e                   op_i,
  input  logic                  sub_i,
  input  logic [W-1:0]          a_i,
  input  logic [W-1:0]          sum_i,
  input  logic [W-1:0]          cin_eff_i,
  input  logic [W-1:0]          cout_i,
  input  logic [NB-1:0]         top_i,
  input  logic [NB-1:0][IW-1:0] owner_i,
  output logic [W-1:0]          res_o,
  output logic [NB-1:0]         byte_c_o,
  output logic [NB-1:0]         byte_v_o
);
  logic [W-1:0] sum_sh;
  assign sum_sh = {1'b0, sum_i[W-1:1]};

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      byte_c_o[k] = cout_i[k*LANE_W + LANE_W-1];
      byte_v_o[k] = cin_eff_i[k*LANE_W + LANE_W-1] ^ cout_i[k*LANE_W + LANE_W-1];
    end
    res_o = sum_i;
    for (int k = 0; k < NB; k++) begin
      logic lc, lv, neg;
      logic [LANE_W-1:0] wrap, avg, ssat, usat;
      lc   = byte_c_o[owner_i[k]];
      lv   = byte_v_o[owner_i[k]];
      neg  = a_i[owner_i[k]*LANE_W + LANE_W-1];
      wrap = sum_i[k*LANE_W +: LANE_W];
      avg  = sum_sh[k*LANE_W +: LANE_W];
      if (top_i[k]) avg[LANE_W-1] = lc ^ sub_i;
      ssat = top_i[k] ? {neg, {(LANE_W-1){~neg}}} : {LANE_W{~neg}};
      if (!lv) ssat = wrap;
      usat = (lc ^ sub_i) ? {LANE_W{~sub_i}} : wrap;
      unique case (op_i)
        OP_WRAP: res_o[k*LANE_W +: LANE_W] = wrap;
        OP_AVG:  res_o[k*LANE_W +: LANE_W] = avg;
        OP_SSAT: res_o[k*LANE_W +: LANE_W] = ssat;
        default: res_o[k*LANE_W +: LANE_W] = usat;
      endcase
    end
  end
endmodule

// File: rtl/subword_adder.sv
module subword_adder
  import subword_pkg::*;
#(
  parameter int W      = 32,
  parameter int LANE_W = 8,
  localparam int NB    = W / LANE_W,
  localparam int IW    = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          sub_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    op_i,
  output logic [W-1:0]  sum_o,
  output logic [NB-1:0] cout_o,
  output logic [NB-1:0] ovf_o
);
  mode_e mode;
  op_e   op;
  assign mode = mode_e'(mode_i);
  assign op   = op_e'(op_i);

  logic [NB-1:0]         split, top, lane_vld;
  logic [NB-1:0][IW-1:0] owner, lane_top;
  logic [W-1:0]          b_eff, raw_sum, cin_eff, cout_bits, res;
  logic [NB-1:0]         byte_c, byte_v, cout_d, ovf_d;

  sw_lane_map #(.NB(NB)) u_map (
    .mode_i    (mode),
    .split_o   (split),
    .top_o     (top),
    .owner_o   (owner),
    .lane_vld_o(lane_vld),
    .lane_top_o(lane_top)
  );

  assign b_eff = b_i ^ {W{sub_i}};

  sw_prefix_adder #(.W(W), .LANE_W(LANE_W)) u_add (
    .a_i      (a_i),
    .b_i      (b_eff),
    .cin_i    (sub_i),
    .split_i  (split),
    .sum_o    (raw_sum),
    .cin_eff_o(cin_eff),
    .cout_o   (cout_bits)
  );

  sw_lane_post #(.W(W), .LANE_W(LANE_W)) u_post (
    .op_i     (op),
    .sub_i    (sub_i),
    .a_i      (a_i),
    .sum_i    (raw_sum),
    .cin_eff_i(cin_eff),
    .cout_i   (cout_bits),
    .top_i    (top),
    .owner_i  (owner),
    .res_o    (res),
    .byte_c_o (byte_c),
    .byte_v_o (byte_v)
  );

  always_comb begin
    for (int l = 0; l < NB; l++) begin
      cout_d[l] = lane_vld[l] & byte_c[lane_top[l]];
      ovf_d[l]  = lane_vld[l] & byte_v[lane_top[l]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      cout_o <= '0;
      ovf_o  <= '0;
    end else begin
      sum_o  <= res;
      cout_o <= cout_d;
      ovf_o  <= ovf_d;
    end
  end

  AST_LOW_LANE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_WRAP && !sub_i) |=> sum_o[LANE_W-1:0] == $past(LANE_W'(a_i[LANE_W-1:0] + b_i[LANE_W-1:0]))); // R11
  AST_BYTE_ISOLATION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_B8 && op == OP_WRAP && !sub_i) |=>
      sum_o[2*LANE_W-1:LANE_W] == $past(LANE_W'(a_i[2*LANE_W-1:LANE_W] + b_i[2*LANE_W-1:LANE_W]))); // R5
  AST_UNUSED_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_W32) |=> (cout_o[NB-1:1] == '0 && ovf_o[NB-1:1] == '0)); // R6
  AST_USAT_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_B8 && op == OP_USAT && !sub_i) |=> (!cout_o[0] || sum_o[LANE_W-1:0] == '1)); // R10
  AST_SSAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_B8 && op == OP_SSAT) |=>
      (!ovf_o[0] || sum_o[LANE_W-1:0] == {1'b0, {(LANE_W-1){1'b1}}} ||
       sum_o[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}})); // R9
endmodule

// File: tb/subword_adder_test.sv
`timescale 1ns/1ps
module subword_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        sub = 1'b0;
  logic [1:0]  mode = '0, op = '0;
  logic [31:0] sum;
  logic [3:0]  cout, ovf;
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] prev_sum = '0;
  logic [3:0]  prev_c = '0, prev_v = '0;

  always #2.5 clk = ~clk;

  subword_adder uut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sub_i(sub),
    .mode_i(mode), .op_i(op), .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  function automatic void ref_model(input logic [31:0] ia, ib, input logic s,
      input logic [1:0] m, o, output logic [31:0] r, output logic [3:0] c, v);
    int w = (m == 2'b00) ? 32 : (m == 2'b01) ? 16 : 8;
    int nl = 32 / w;
    longint unsigned mask = (64'd1 << w) - 1;
    longint unsigned av, bv, full, rr, co, am, bm, rm;
    bit ov;
    r = '0; c = '0; v = '0;
    for (int l = 0; l < nl; l++) begin
      av = (longint'(ia) >> (l*w)) & mask;
      bv = (longint'(ib) >> (l*w)) & mask;
      if (s) bv = (~bv) & mask;
      full = av + bv + longint'(s);
      co = (full >> w) & 1;
      rr = full & mask;
      am = (av >> (w-1)) & 1;
      bm = (bv >> (w-1)) & 1;
      rm = (rr >> (w-1)) & 1;
      ov = (am == bm) && (rm != am);
      case (o)
        2'b01: rr = (rr >> 1) | ((co ^ longint'(s)) << (w-1));
        2'b10: if (ov) rr = am ? (64'd1 << (w-1)) : (mask >> 1);
        2'b11: if ((co ^ longint'(s)) != 0) rr = s ? 0 : mask;
        default: ;
      endcase
      r = r | 32'(rr << (l*w));
      c[l] = co[0];
      v[l] = ov;
    end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ia, ib, input logic s,
      input logic [1:0] m, o, input string tag);
    logic [31:0] er;
    logic [3:0] ec, ev;
    string t;
    @(negedge clk);
    a = ia; b = ib; sub = s; mode = m; op = o;
    #1;
    chk("R11 hold sum", sum, prev_sum);
    chk("R11 hold flags", {24'd0, cout, ovf}, {24'd0, prev_c, prev_v});
    ref_model(ia, ib, s, m, o, er, ec, ev);
    if (tag != "") t = tag;
    else case (o)
      2'b00: t = (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : "R4";
      2'b01: t = "R8";
      2'b10: t = "R9";
      default: t = "R10";
    endcase
    @(negedge clk);
    chk(t, sum, er);
    chk("R6", {28'd0, cout}, {28'd0, ec});
    chk("R7", {28'd0, ovf}, {28'd0, ev});
    prev_sum = er; prev_c = ec; prev_v = ev;
  endtask

  initial begin
    a = 32'hDEAD_BEEF; b = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk("R1 sum", sum, '0);
    chk("R1 flags", {24'd0, cout, ovf}, '0);
    a = '0; b = '0;
    rst_n = 1'b1;
    @(negedge clk);
    prev_sum = '0; prev_c = 4'b0001; prev_v = '0;
    prev_c = '0;
    // first apply after reset: outputs reflect a=b=0 wrap add in 32-bit mode
    apply(32'hFFFF_FFFF, 32'h0000_0001, 0, 2'b00, 2'b00, "R2");
    apply(32'h7FFF_FFFF, 32'h0000_0001, 0, 2'b00, 2'b00, "R2");
    apply(32'h0000_0000, 32'h0000_0001, 1, 2'b00, 2'b00, "R2");
    apply(32'h0001_FFFF, 32'h0000_0001, 0, 2'b01, 2'b00, "R5");
    apply(32'h01FF_00FF, 32'h0001_0001, 0, 2'b10, 2'b00, "R5");
    apply(32'h0000_0000, 32'h0101_0101, 1, 2'b10, 2'b00, "R5");
    apply(32'h7F80_FF01, 32'h0101_01FF, 0, 2'b11, 2'b00, "R4");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2'b10, 2'b01, "R8");
    apply(32'h0003_0010, 32'h0005_0020, 1, 2'b01, 2'b01, "R8");
    apply(32'h7F80_0180, 32'h0101_0101, 0, 2'b10, 2'b10, "R9");
    apply(32'h8000_7FFF, 32'h0001_FFFF, 1, 2'b01, 2'b10, "R9");
    apply(32'hF0FF_0010, 32'h2001_0020, 0, 2'b10, 2'b11, "R10");
    apply(32'h0010_0005, 32'h0020_0003, 1, 2'b01, 2'b11, "R10");
    for (int i = 0; i < 800; i++)
      apply($urandom, $urandom, 1'($urandom), 2'($urandom), 2'($urandom), "");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R11 watchdog: got hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule